// File: doc/BRIEF.md
# Host Interrupt Aggregator

The block gathers single-cycle event pulses from the functions inside a device into a sticky 16-bit status vector and drives one interrupt pin toward the host. A mask register decides which status bits may raise the pin. A mask bit of 1 blocks its status bit and a mask bit of 0 lets it through. The mask can be written whole, or changed one bit at a time through write-one-to-set and write-one-to-clear ports, so software never needs a read-modify-write.

The host reaches the block over a simple register bus with address, write enable, write data, read enable and read data. Status can be read in two ways. A peek read leaves the status untouched. A take read returns the status and then empties it. Individual bits can also be retired through a write-one acknowledge port. Two configuration inputs gate the pin and choose its polarity.

Event bit meanings: 0 first receive buffer, 1 transmit data, 2 transmit transfer, 3 second receive buffer, 4 receive transfer, 5 and 6 mailbox events A and B, 7 wake, 8 and 9 trace A and B, 10 command done, 14 initialisation done, 16 and 17 coexistence sense on and off. Event lines at 16 and above are not stored in the 16-bit status.

Top module: `host_irq_aggr`

## Requirements
- R1: After reset the mask reads 0x0000_0001, both status views read 0, and `irq_o` sits at its inactive level.
- R2: A write to the mask register (address 0) loads all 32 bits, and a read of address 0 returns them.
- R3: A write to the mask-set port (address 1) sets every mask bit written as 1. Mask bits written as 0 keep their value.
- R4: A write to the mask-clear port (address 2) clears every mask bit written as 1. Mask bits written as 0 keep their value.
- R5: A pulse on `evt_i[n]` for n below 16 sets status bit n, and the bit holds until it is cleared. Pulses on lines 16 and above leave status unchanged.
- R6: A read of the peek view (address 3) returns the status in bits 15:0 with zeros above, and it leaves the status unchanged.
- R7: A read of the take view (address 4) returns the status and then clears every status bit.
- R8: A write to the acknowledge port (address 5) clears each status bit written as 1. Both views then show the change, and bits written as 0 are unaffected.
- R9: An event that arrives in the same cycle as a take read or an acknowledge of its bit leaves that bit set.
- R10: One cycle after some status bit is set and unmasked, with the pin enabled, `irq_o` goes active. One cycle after no such bit remains, it returns to inactive.
- R11: When `cfg_irq_en_i` is 0, `irq_o` is inactive from the next cycle on, whatever the status.
- R12: `cfg_active_low_i` = 1 makes the active level 0 and the inactive level 1. With 0, the active level is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | EVT_W (18) | Event pulses, one line per source |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe; a take read clears status at the clock edge |
| rd_data_o | output | 32 | Read data, valid during rd_en_i, zero otherwise |
| cfg_irq_en_i | input | 1 | Enables the interrupt pin |
| cfg_active_low_i | input | 1 | Selects an active-low pin |
| irq_o | output | 1 | Host interrupt pin |

## Verification
The hardest case to reach from the ports is an event that lands in exactly the cycle in which a clear takes effect. The clear may come from a take read or from an acknowledge write, and the race must resolve in favour of the event. The bench drives the event line and the bus strobe in the same half-cycle window. It then reads the peek view to show that only the racing bit survived. It also checks the value the take read returned, to show that the racing event was not counted in that read.

// File: rtl/hia_pkg.sv
package hia_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned BUS_W  = 32;

  typedef enum logic [REG_AW-1:0] {
    A_MASK = 3'd0,
    A_MSET = 3'd1,
    A_MCLR = 3'd2,
    A_PEEK = 3'd3,
    A_TAKE = 3'd4,
    A_ACK  = 3'd5
  } hia_addr_e;

  localparam int unsigned EV_RXB0     = 0;
  localparam int unsigned EV_TXDATA   = 1;
  localparam int unsigned EV_TXXFER   = 2;
  localparam int unsigned EV_RXB1     = 3;
  localparam int unsigned EV_RXXFER   = 4;
  localparam int unsigned EV_MBOX_A   = 5;
  localparam int unsigned EV_MBOX_B   = 6;
  localparam int unsigned EV_WAKE     = 7;
  localparam int unsigned EV_TRACE_A  = 8;
  localparam int unsigned EV_TRACE_B  = 9;
  localparam int unsigned EV_CMD_DONE = 10;
  localparam int unsigned EV_INIT_DONE = 14;
  localparam int unsigned EV_COEX_ON  = 16;
  localparam int unsigned EV_COEX_OFF = 17;
endpackage

// File: rtl/hia_regif.sv
module hia_regif #(
  parameter int unsigned STS_W  = 16,
  parameter int unsigned MASK_W = 32
) (
  input  logic [hia_pkg::REG_AW-1:0] addr_i,
  input  logic                       wr_en_i,
  input  logic [hia_pkg::BUS_W-1:0]  wr_data_i,
  input  logic                       rd_en_i,
  input  logic [MASK_W-1:0]          mask_i,
  input  logic [STS_W-1:0]           sts_i,
  output logic                       mask_load_o,
  output logic [MASK_W-1:0]          mask_set_o,
  output logic [MASK_W-1:0]          mask_clr_o,
  output logic [STS_W-1:0]           sts_clr_o,
  output logic [hia_pkg::BUS_W-1:0]  rd_data_o
);
  import hia_pkg::*;

  logic is_wr_mask, is_wr_set, is_wr_clr, is_wr_ack, is_rd_take;

  always_comb begin
    is_wr_mask = wr_en_i && (addr_i == A_MASK);
    is_wr_set  = wr_en_i && (addr_i == A_MSET);
    is_wr_clr  = wr_en_i && (addr_i == A_MCLR);
    is_wr_ack  = wr_en_i && (addr_i == A_ACK);
    is_rd_take = rd_en_i && (addr_i == A_TAKE);
  end

  assign mask_load_o = is_wr_mask;
  assign mask_set_o  = is_wr_set ? wr_data_i[MASK_W-1:0] : '0;
  assign mask_clr_o  = is_wr_clr ? wr_data_i[MASK_W-1:0] : '0;

  // take read empties everything; ack retires only the bits written as 1
  always_comb begin
    sts_clr_o = '0;
    if (is_rd_take) sts_clr_o = '1;
    else if (is_wr_ack) sts_clr_o = wr_data_i[STS_W-1:0];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        A_MASK:         rd_data_o = BUS_W'(mask_i);
        A_PEEK, A_TAKE: rd_data_o = BUS_W'(sts_i);
        default:        rd_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/hia_mask.sv
module hia_mask #(
  parameter int unsigned    MASK_W  = 32,
  parameter logic [31:0]    RST_VAL = 32'h0000_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MASK_W-1:0] load_val_i,
  input  logic [MASK_W-1:0] set_i,
  input  logic [MASK_W-1:0] clr_i,
  output logic [MASK_W-1:0] mask_o
);
  logic [MASK_W-1:0] mask_q, mask_d;

  always_comb begin
    if (load_i) mask_d = load_val_i;
    else        mask_d = (mask_q | set_i) & ~clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= RST_VAL[MASK_W-1:0];
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/hia_status.sv
module hia_status #(
  parameter int unsigned STS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STS_W-1:0] evt_i,
  input  logic [STS_W-1:0] clr_i,
  output logic [STS_W-1:0] sts_o
);
  for (genvar b = 0; b < STS_W; b++) begin : g_bit
    logic bit_q;
    // a new event beats a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (evt_i[b]) bit_q <= 1'b1;
      else if (clr_i[b]) bit_q <= 1'b0;
    end
    assign sts_o[b] = bit_q;
  end
endmodule

// File: rtl/hia_pin.sv
module hia_pin #(
  parameter int unsigned STS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STS_W-1:0] sts_i,
  input  logic [STS_W-1:0] mask_i,
  input  logic             en_i,
  input  logic             active_low_i,
  output logic             irq_o
);
  logic live_q;
  logic any_open;

  assign any_open = |(sts_i & ~mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= en_i & any_open;
  end

  assign irq_o = live_q ^ active_low_i;
endmodule

// File: rtl/host_irq_aggr.sv
module host_irq_aggr #(
  parameter int unsigned EVT_W  = 18,
  parameter int unsigned STS_W  = 16,
  parameter int unsigned MASK_W = 32,
  parameter logic [31:0] MASK_RST = 32'h0000_0001
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [EVT_W-1:0]           evt_i,
  input  logic [hia_pkg::REG_AW-1:0] addr_i,
  input  logic                       wr_en_i,
  input  logic [hia_pkg::BUS_W-1:0]  wr_data_i,
  input  logic                       rd_en_i,
  output logic [hia_pkg::BUS_W-1:0]  rd_data_o,
  input  logic                       cfg_irq_en_i,
  input  logic                       cfg_active_low_i,
  output logic                       irq_o
);
  logic [MASK_W-1:0] mask_q;
  logic [MASK_W-1:0] mask_set, mask_clr;
  logic              mask_load;
  logic [STS_W-1:0]  sts_q;
  logic [STS_W-1:0]  sts_clr;
  logic              unused_evt_hi;

  // sources above the status width have no status slot
  assign unused_evt_hi = ^evt_i[EVT_W-1:STS_W];

  hia_regif #(.STS_W(STS_W), .MASK_W(MASK_W)) u_regif (
    .addr_i      (addr_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_en_i     (rd_en_i),
    .mask_i      (mask_q),
    .sts_i       (sts_q),
    .mask_load_o (mask_load),
    .mask_set_o  (mask_set),
    .mask_clr_o  (mask_clr),
    .sts_clr_o   (sts_clr),
    .rd_data_o   (rd_data_o)
  );

  hia_mask #(.MASK_W(MASK_W), .RST_VAL(MASK_RST)) u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (mask_load),
    .load_val_i (wr_data_i[MASK_W-1:0]),
    .set_i      (mask_set),
    .clr_i      (mask_clr),
    .mask_o     (mask_q)
  );

  hia_status #(.STS_W(STS_W)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i[STS_W-1:0]),
    .clr_i  (sts_clr),
    .sts_o  (sts_q)
  );

  hia_pin #(.STS_W(STS_W)) u_pin (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sts_i        (sts_q),
    .mask_i       (mask_q[STS_W-1:0]),
    .en_i         (cfg_irq_en_i),
    .active_low_i (cfg_active_low_i),
    .irq_o        (irq_o)
  );
endmodule

// File: rtl/hia_checker.sv
module hia_checker #(
  parameter int unsigned STS_W  = 16,
  parameter int unsigned MASK_W = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [STS_W-1:0]           evt_i,
  input logic [hia_pkg::REG_AW-1:0] addr_i,
  input logic                       wr_en_i,
  input logic [hia_pkg::BUS_W-1:0]  wr_data_i,
  input logic                       rd_en_i,
  input logic [hia_pkg::BUS_W-1:0]  rd_data_o,
  input logic                       cfg_irq_en_i,
  input logic                       cfg_active_low_i,
  input logic                       irq_o,
  input logic [MASK_W-1:0]          mask_i,
  input logic [STS_W-1:0]           sts_i
);
  import hia_pkg::*;

  assert_mask_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_MASK) |=> mask_i == $past(wr_data_i[MASK_W-1:0]));

  assert_mask_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_MSET) |=>
      (mask_i & $past(wr_data_i[MASK_W-1:0])) == $past(wr_data_i[MASK_W-1:0]));

  assert_mask_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_MCLR) |=> (mask_i & $past(wr_data_i[MASK_W-1:0])) == '0);

  assert_evt_sticks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> (sts_i & $past(evt_i)) == $past(evt_i));

  assert_peek_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_PEEK && !wr_en_i && evt_i == '0) |=> $stable(sts_i));

  assert_take_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_TAKE) |=> (sts_i & ~$past(evt_i)) == '0);

  assert_ack_retires_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_ACK) |=>
      (sts_i & $past(wr_data_i[STS_W-1:0]) & ~$past(evt_i)) == '0);

  assert_pin_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_irq_en_i |=> irq_o == cfg_active_low_i);

  assert_take_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_TAKE) |-> rd_data_o[STS_W-1:0] == sts_i);
endmodule

bind host_irq_aggr hia_checker #(.STS_W(STS_W), .MASK_W(MASK_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .evt_i            (evt_i[STS_W-1:0]),
  .addr_i           (addr_i),
  .wr_en_i          (wr_en_i),
  .wr_data_i        (wr_data_i),
  .rd_en_i          (rd_en_i),
  .rd_data_o        (rd_data_o),
  .cfg_irq_en_i     (cfg_irq_en_i),
  .cfg_active_low_i (cfg_active_low_i),
  .irq_o            (irq_o),
  .mask_i           (mask_q),
  .sts_i            (sts_q)
);

// File: tb/host_irq_aggr_tb_top.sv
`timescale 1ns/1ps
module host_irq_aggr_tb_top;
  localparam int unsigned EVT_W = 18;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [EVT_W-1:0] evt_i = '0;
  logic [2:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        cfg_irq_en_i = 1'b1;
  logic        cfg_active_low_i = 1'b0;
  logic        irq_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  host_irq_aggr #(.EVT_W(EVT_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .cfg_irq_en_i(cfg_irq_en_i),
    .cfg_active_low_i(cfg_active_low_i), .irq_o(irq_o)
  );

  // op 0 = write, 1 = read and compare
  typedef struct packed {
    logic        op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 32'h0000_0001, 8'd1},  // R1 mask reset value
    '{1'b1, 3'd3, 32'h0000_0000, 8'd1},  // R1 status reset value
    '{1'b0, 3'd0, 32'hFFFF_0000, 8'd2},  // R2 whole-mask write
    '{1'b1, 3'd0, 32'hFFFF_0000, 8'd2},
    '{1'b0, 3'd1, 32'h0000_00F0, 8'd3},  // R3 set port
    '{1'b1, 3'd0, 32'hFFFF_00F0, 8'd3},
    '{1'b0, 3'd2, 32'h0F00_0030, 8'd4},  // R4 clear port
    '{1'b1, 3'd0, 32'hF0FF_00C0, 8'd4},
    '{1'b1, 3'd4, 32'h0000_0000, 8'd7},  // R7 take view empty
    '{1'b0, 3'd0, 32'h0000_0000, 8'd2},
    '{1'b1, 3'd0, 32'h0000_0000, 8'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rd_data_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic pulse(input logic [EVT_W-1:0] e);
    @(negedge clk_i);
    evt_i = e;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    check("R1 irq inactive in reset", {31'd0, irq_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 irq inactive after reset", {31'd0, irq_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op == 1'b0) begin
        bus_wr(VECS[i].addr, VECS[i].data);
      end else begin
        bus_rd(VECS[i].addr, rd);
        tests++;
        if (rd !== VECS[i].data) begin
          fails++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h", VECS[i].req, i, rd, VECS[i].data);
        end
      end
    end

    // R5: low events latch, lines 16/17 dropped
    pulse(18'h3_0412);
    bus_rd(3'd3, rd);
    check("R5 latch", rd, 32'h0000_0412);
    bus_rd(3'd3, rd);
    check("R6 peek unchanged", rd, 32'h0000_0412);

    // R10 / R12: pin follows unmasked status, polarity
    check("R10 irq active", {31'd0, irq_o}, 32'd1);
    @(negedge clk_i); cfg_active_low_i = 1'b1; #1;
    check("R12 active-low level", {31'd0, irq_o}, 32'd0);
    @(negedge clk_i); cfg_active_low_i = 1'b0;
    bus_wr(3'd0, 32'h0000_FFFF);
    @(negedge clk_i);
    check("R10 all masked", {31'd0, irq_o}, 32'd0);
    bus_wr(3'd0, 32'h0000_0000);
    @(negedge clk_i);
    check("R10 unmasked again", {31'd0, irq_o}, 32'd1);

    // R8: acknowledge one bit
    bus_wr(3'd5, 32'h0000_0010);
    bus_rd(3'd3, rd);
    check("R8 ack one bit", rd, 32'h0000_0402);

    // R7: take read returns then empties
    bus_rd(3'd4, rd);
    check("R7 take data", rd, 32'h0000_0402);
    bus_rd(3'd3, rd);
    check("R7 empty after take", rd, 32'h0000_0000);
    check("R10 irq drops", {31'd0, irq_o}, 32'd0);

    // R11: pin disabled
    cfg_irq_en_i = 1'b0;
    pulse(18'h0_0004);
    @(negedge clk_i);
    check("R11 disabled pin", {31'd0, irq_o}, 32'd0);
    cfg_irq_en_i = 1'b1;
    @(negedge clk_i);
    check("R11 re-enabled pin", {31'd0, irq_o}, 32'd1);
    bus_rd(3'd4, rd);

    // R9: event racing an acknowledge
    pulse(18'h0_0009);
    @(negedge clk_i);
    addr_i = 3'd5; wr_data_i = 32'h0000_0009; wr_en_i = 1'b1; evt_i = 18'h0_0008;
    @(negedge clk_i);
    wr_en_i = 1'b0; evt_i = '0;
    bus_rd(3'd3, rd);
    check("R9 event beats ack", rd, 32'h0000_0008);

    // R9: event racing a take read
    @(negedge clk_i);
    addr_i = 3'd4; rd_en_i = 1'b1; evt_i = 18'h0_0001;
    #1 rd = rd_data_o;
    @(negedge clk_i);
    rd_en_i = 1'b0; evt_i = '0;
    check("R9 take data excludes racing event", rd, 32'h0000_0008);
    bus_rd(3'd3, rd);
    check("R9 event beats take", rd, 32'h0000_0001);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule